// File: doc/BRIEF.md
# ECC Error Location Correction Unit

This block sits behind a BCH syndrome decoder and repairs one buffered sector at a time. The decoder reports its results in packed words. A 32-bit error-count word holds one 4-bit count for each of up to eight sectors. A set of 32-bit location words holds the 13-bit bit positions of the errors, two to a word. When software or a sequencer pulses `start` for one sector, the unit reads that sector's count and then walks the locations. For each location that falls inside the sector buffer, it flips the indicated bit through a read-modify-write port.

The sector buffer is addressed as a single byte space. Bytes 0 to 511 hold the sector data and bytes 512 to 519 hold the metadata, so a metadata location lands at its byte index minus 512 within that region. Locations beyond the buffer point into the parity bytes. Those are counted but never written. The unit reports the number of corrected bits, or an uncorrectable flag, and keeps one finished flag per sector so that a page of sectors can be tracked.

Top module: `ecc_loc_fixer`

## Requirements
- R1: The count for sector s is taken from bits [4s+3:4s] of `err_count_word`. Counts in the fields of other sectors have no effect.
- R2: A count of 0 raises `done` in the cycle after `start` is sampled, with `corr_bits` = 0, `uncorrectable` = 0 and no buffer write.
- R3: A count of 15, or any count above the supported strength of 12, raises `done` in the cycle after `start` with `uncorrectable` = 1 and `corr_bits` = 0. No buffer byte changes.
- R4: Location i is taken from word i/2 of `loc_words`, where word w occupies bits [32w+31:32w]. Even i uses bits [12:0] of its word and odd i uses bits [28:16]. Bits 13 to 15 and 29 to 31 are ignored.
- R5: For a location L, the byte address is L>>3 and the bit is L[2:0]. The byte written is `buf_rdata` XOR (1<<L[2:0]). Addresses 0 to 511 are data and 512 to 519 are metadata.
- R6: A location whose byte index is 520 or more (parity) causes no buffer write, but it still counts toward `corr_bits`.
- R7: One location is handled per cycle. With a count n of 1 to 12, `done` rises n+1 cycles after the `start` edge, and `corr_bits` = n from then until the next accepted start.
- R8: `busy` is high while locations are being applied. A `start` raised while busy is ignored.
- R9: Bit s of `sector_done` is set when sector s finishes, whatever the outcome. An accepted start for sector 0 clears every flag first.
- R10: After reset the unit is idle, with `done`, `busy`, `buf_we`, `uncorrectable`, `corr_bits` and `sector_done` all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin correcting the selected sector |
| sect_sel | input | 3 | Sector index to correct |
| err_count_word | input | 32 | Packed 4-bit error counts, one per sector |
| loc_words | input | 192 | Six packed words of error locations, two per word |
| busy | output | 1 | Locations are being applied |
| done | output | 1 | One-cycle pulse when a sector finishes |
| corr_bits | output | 4 | Number of locations processed for the last sector |
| uncorrectable | output | 1 | Last sector could not be corrected |
| sector_done | output | 8 | Finished flag per sector |
| buf_addr | output | 10 | Byte address into the sector buffer |
| buf_rdata | input | 8 | Buffer byte at `buf_addr`, combinational read |
| buf_we | output | 1 | Write strobe for the corrected byte |
| buf_wdata | output | 8 | Corrected byte |

## Verification
The assertions hold on every cycle. They check that buffer writes happen only while busy and only inside the 520-byte buffer, that `done` never coincides with `busy`, that a finished uncorrectable sector reports zero corrections, that the count never exceeds the strength, and that a finished sector's flag is set on the next edge. Only the bench scenarios can show the rest. These are the right count field being chosen among noisy neighbours, the even/odd unpacking of the location words, whether a flip lands on the correct bit and byte, parity locations leaving memory untouched, two flips of the same byte in consecutive cycles cancelling, and the exact latency of `done` for each count.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
    typedef enum logic {
        FIX_IDLE  = 1'b0,
        FIX_APPLY = 1'b1
    } fix_state_e;

    localparam int BIT_SEL_W = 3;
endpackage

// File: rtl/ecc_loc_pick.sv
module ecc_loc_pick #(
    parameter int LOC_W = 13,
    parameter int SLOTS = 6,
    parameter int IDX_W = 4
) (
    input  logic [SLOTS*32-1:0] words,
    input  logic [IDX_W-1:0]    idx,
    output logic [LOC_W-1:0]    loc
);
    localparam int NLOC = 2 * SLOTS;

    logic [LOC_W-1:0] locs [NLOC];

    for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
        assign locs[2*g]   = words[32*g      +: LOC_W];
        assign locs[2*g+1] = words[32*g + 16 +: LOC_W];
    end

    always_comb begin
        loc = '0;
        for (int k = 0; k < NLOC; k++) begin
            if (idx == IDX_W'(k)) loc = locs[k];
        end
    end
endmodule

// File: rtl/ecc_loc_classify.sv
module ecc_loc_classify
    import ecc_fix_pkg::*;
#(
    parameter int LOC_W      = 13,
    parameter int DATA_BYTES = 512,
    parameter int META_BYTES = 8,
    parameter int ADDR_W     = 10
) (
    input  logic [LOC_W-1:0]  loc,
    output logic              in_buffer,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        bit_mask
);
    localparam int BYTE_IDX_W = LOC_W - BIT_SEL_W;
    localparam int BUF_BYTES  = DATA_BYTES + META_BYTES;

    logic [BYTE_IDX_W-1:0] byte_idx;

    always_comb begin
        byte_idx  = loc[LOC_W-1:BIT_SEL_W];
        in_buffer = (byte_idx < BYTE_IDX_W'(BUF_BYTES));
        byte_addr = ADDR_W'(byte_idx);
        bit_mask  = 8'b1 << loc[BIT_SEL_W-1:0];
    end
endmodule

// File: rtl/ecc_done_track.sv
module ecc_done_track #(
    parameter int SECTORS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_all,
    input  logic                       set_en,
    input  logic [$clog2(SECTORS)-1:0] set_idx,
    output logic [SECTORS-1:0]         flags
);
    typedef struct packed {
        logic [SECTORS-1:0] flags;
    } trk_t;

    trk_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr_all) r_d.flags = '0;
        if (set_en)  r_d.flags[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags = r_q.flags;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> flags[$past(set_idx)]); // R9
endmodule

// File: rtl/ecc_loc_fixer.sv
module ecc_loc_fixer
    import ecc_fix_pkg::*;
#(
    parameter int SECTORS    = 8,
    parameter int CNT_W      = 4,
    parameter int LOC_W      = 13,
    parameter int MAX_T      = 12,
    parameter int DATA_BYTES = 512,
    parameter int META_BYTES = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        start,
    input  logic [$clog2(SECTORS)-1:0]                  sect_sel,
    input  logic [SECTORS*CNT_W-1:0]                    err_count_word,
    input  logic [(MAX_T/2)*32-1:0]                     loc_words,
    output logic                                        busy,
    output logic                                        done,
    output logic [CNT_W-1:0]                            corr_bits,
    output logic                                        uncorrectable,
    output logic [SECTORS-1:0]                          sector_done,
    output logic [$clog2(DATA_BYTES+META_BYTES)-1:0]    buf_addr,
    input  logic [7:0]                                  buf_rdata,
    output logic                                        buf_we,
    output logic [7:0]                                  buf_wdata
);
    localparam int SEC_W     = $clog2(SECTORS);
    localparam int SLOTS     = MAX_T / 2;
    localparam int ADDR_W    = $clog2(DATA_BYTES + META_BYTES);
    localparam int BUF_BYTES = DATA_BYTES + META_BYTES;

    typedef struct packed {
        fix_state_e         state;
        logic [CNT_W-1:0]   idx;
        logic [CNT_W-1:0]   target;
        logic [SLOTS*32-1:0] words;
        logic [SEC_W-1:0]   sect;
        logic [CNT_W-1:0]   count;
        logic               unc;
        logic               done;
    } fix_t;

    fix_t r_q, r_d;

    logic [CNT_W-1:0]  cnt_sel;
    logic [LOC_W-1:0]  cur_loc;
    logic              cur_in_buf;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        cur_mask;
    logic              flag_clr;
    logic [SEC_W-1:0]  flag_idx;

    ecc_loc_pick #(.LOC_W(LOC_W), .SLOTS(SLOTS), .IDX_W(CNT_W)) u_pick (
        .words (r_q.words),
        .idx   (r_q.idx),
        .loc   (cur_loc)
    );

    ecc_loc_classify #(
        .LOC_W(LOC_W), .DATA_BYTES(DATA_BYTES),
        .META_BYTES(META_BYTES), .ADDR_W(ADDR_W)
    ) u_class (
        .loc       (cur_loc),
        .in_buffer (cur_in_buf),
        .byte_addr (cur_addr),
        .bit_mask  (cur_mask)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cnt_sel  = err_count_word[sect_sel*CNT_W +: CNT_W];
        flag_clr = 1'b0;
        flag_idx = r_q.sect;
        case (r_q.state)
            FIX_IDLE: begin
                flag_idx = sect_sel;
                if (start) begin
                    flag_clr  = (sect_sel == '0);
                    r_d.sect  = sect_sel;
                    r_d.words = loc_words;
                    r_d.idx   = '0;
                    r_d.count = '0;
                    r_d.unc   = 1'b0;
                    if (cnt_sel == '0) begin
                        r_d.done = 1'b1;
                    end else if (cnt_sel == '1 || cnt_sel > CNT_W'(MAX_T)) begin
                        r_d.done = 1'b1;
                        r_d.unc  = 1'b1;
                    end else begin
                        r_d.state  = FIX_APPLY;
                        r_d.target = cnt_sel;
                    end
                end
            end
            FIX_APPLY: begin
                r_d.idx = r_q.idx + 1'b1;
                if (r_q.idx == r_q.target - 1'b1) begin
                    r_d.state = FIX_IDLE;
                    r_d.done  = 1'b1;
                    r_d.count = r_q.target;
                end
            end
            default: r_d.state = FIX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    ecc_done_track #(.SECTORS(SECTORS)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (flag_clr),
        .set_en  (r_d.done),
        .set_idx (flag_idx),
        .flags   (sector_done)
    );

    assign busy          = (r_q.state == FIX_APPLY);
    assign done          = r_q.done;
    assign corr_bits     = r_q.count;
    assign uncorrectable = r_q.unc;
    assign buf_we        = busy && cur_in_buf;
    assign buf_addr      = cur_addr;
    assign buf_wdata     = buf_rdata ^ cur_mask;

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> busy); // R8
    AST_WRITE_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (int'(buf_addr) < BUF_BYTES)); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_UNCORR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> (corr_bits == '0)); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (corr_bits <= CNT_W'(MAX_T))); // R7
    AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> ($countones(buf_wdata ^ buf_rdata) == 1)); // R5
endmodule

// File: tb/ecc_loc_fixer_test.sv
module ecc_loc_fixer_test;
    localparam int NBYTES = 520;

    typedef struct packed {
        logic [2:0]   sect;
        logic [31:0]  errw;
        logic [191:0] locs;
        logic [3:0]   cnt;
        logic         unc;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 32'h00000003, {32'h0, 32'h0, 32'h0, 32'h0, 32'h00000FFF, 32'h00080000}, 4'd3, 1'b0},
        '{3'd2, 32'h00000200, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hF03FF000}, 4'd2, 1'b0},
        '{3'd1, 32'h00000040, {32'h0, 32'h0, 32'h0, 32'h0, 32'h00640064, 32'h1FFF1040}, 4'd4, 1'b0},
        '{3'd7, 32'hF0000000, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0}, 4'd0, 1'b1},
        '{3'd3, 32'h0000C000, {32'h010300FA, 32'h00F100E8, 32'h00DF00D6, 32'h00CD00C4, 32'h00BB00B2, 32'h00A900A0}, 4'd12, 1'b0},
        '{3'd4, 32'h111D1111, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000008}, 4'd0, 1'b1},
        '{3'd5, 32'hFF0FFFFF, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00100010}, 4'd0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   sect_sel = '0;
    logic [31:0]  err_count_word = '0;
    logic [191:0] loc_words = '0;
    logic         busy, done, uncorrectable, buf_we;
    logic [3:0]   corr_bits;
    logic [7:0]   sector_done, buf_rdata, buf_wdata;
    logic [9:0]   buf_addr;

    logic [7:0] mem     [NBYTES];
    logic [7:0] exp_mem [NBYTES];
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2ns clk = ~clk;

    ecc_loc_fixer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sect_sel(sect_sel),
        .err_count_word(err_count_word), .loc_words(loc_words),
        .busy(busy), .done(done), .corr_bits(corr_bits),
        .uncorrectable(uncorrectable), .sector_done(sector_done),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we),
        .buf_wdata(buf_wdata)
    );

    assign buf_rdata = (int'(buf_addr) < NBYTES) ? mem[buf_addr] : 8'h00;

    always @(posedge clk) begin
        if (buf_we && int'(buf_addr) < NBYTES) mem[buf_addr] <= buf_wdata;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Expected effect of a corrected sector, from the location format rules
    task automatic model_apply(input logic [191:0] locs, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            logic [12:0] l;
            int b;
            w = locs[32*(i/2) +: 32];
            l = (i % 2 == 1) ? w[28:16] : w[12:0];
            b = int'(l >> 3);
            if (b < NBYTES) exp_mem[b] = exp_mem[b] ^ (8'b1 << l[2:0]);
        end
    endtask

    task automatic compare_mem(input string tag);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < NBYTES; a++) begin
            if (mem[a] !== exp_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        chk(bad == 0, tag, first, -1);
    endtask

    // Start pulse, then count cycles until done is seen
    task automatic run_sector(input logic [2:0] s, input logic [31:0] ew,
                              input logic [191:0] lw, output int lat);
        @(negedge clk);
        start = 1'b1; sect_sel = s; err_count_word = ew; loc_words = lw;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 40);
    endtask

    initial begin
        #(4ns * 150000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        for (int a = 0; a < NBYTES; a++) begin
            mem[a]     = 8'(a) ^ 8'h5A;
            exp_mem[a] = 8'(a) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !buf_we, "R10", {busy, done, buf_we}, 0);
        chk(corr_bits == 0 && !uncorrectable, "R10", corr_bits, 0);
        chk(sector_done == 0, "R10", sector_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10", {busy, done}, 0);

        // Vector table: R1 field select, R2 zero count, R3 uncorrectable,
        // R4 unpacking, R5 flips, R6 parity skip, R7 latency and count
        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            int exp_lat;
            t = VECS[v];
            run_sector(t.sect, t.errw, t.locs, lat);
            exp_lat = t.unc ? 1 : int'(t.cnt) + 1;
            chk(lat == exp_lat, "R7 latency", lat, exp_lat);
            chk(corr_bits == t.cnt, "R1 R7 count", corr_bits, t.cnt);
            chk(uncorrectable == t.unc, "R3 uncorrectable", uncorrectable, t.unc);
            if (!t.unc) model_apply(t.locs, int'(t.cnt));
            compare_mem("R4 R5 R6 buffer");
        end
        // R9 flags after sectors 0,2,1,7,3,4,5
        chk(sector_done == 8'hBF, "R9 flags", sector_done, 8'hBF);

        // R8 start while busy is ignored
        @(negedge clk);
        start = 1'b1; sect_sel = 3'd3; err_count_word = VECS[4].errw; loc_words = VECS[4].locs;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8 busy", busy, 1);
        @(negedge clk);
        start = 1'b1; sect_sel = 3'd6; err_count_word = 32'h0; loc_words = '0;
        lat = 2;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 40);
        chk(lat == 13, "R8 R7 latency", lat, 13);
        chk(corr_bits == 12, "R8 count", corr_bits, 12);
        chk(sector_done[6] == 1'b0, "R8 flag", sector_done[6], 0);
        model_apply(VECS[4].locs, 12);
        compare_mem("R8 buffer");

        // R9 start on sector 0 clears other flags; R2 zero count
        run_sector(3'd0, 32'hFFFFFFF0, 192'h0, lat);
        chk(lat == 1, "R2 latency", lat, 1);
        chk(corr_bits == 0 && !uncorrectable, "R2 result", corr_bits, 0);
        chk(sector_done == 8'h01, "R9 clear", sector_done, 8'h01);
        @(negedge clk);
        chk(!done, "R7 pulse", done, 0);
        compare_mem("R2 buffer");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule